// File: doc/BRIEF.md
# TDM Clock Qualifier and Serial-Clock Start Sequencer

This block decides whether an incoming TDM clock is present and running at the right rate, and then brings the serial audio interface up in a fixed order. It runs on a free-running reference clock. A counter in the TDM clock domain counts rising edges. Its value crosses into the reference domain as Gray code. Once per measurement window, the block takes the difference between two successive samples and compares it against an inclusive range set on input ports.

A single in-range window is not enough to trust the clock. The qualified flag rises only after several in-range windows in a row. Any one window outside the range drops the flag at once. When the flag has been high for a long start-up delay, the block turns on the bit-clock and frame-clock enables. The delay is long enough to cover the lock time of a downstream PLL. The codec reset is released later still, on the first rising edge of the receive 1x clock that the block sees after the delay.

A second, softer reset input holds the sequence in its idle state without clearing the qualifier. Losing the qualified flag also sends the sequencer back to idle.

Top module: `tdm_qual_seq`

## Requirements
- R1: While `rst_main_n` is low, `clk_good`, `bclk_en` and `lrclk_en` are 0, and `codec_rst_n` is 0. `codec_rst_n` goes low asynchronously, without waiting for a clock edge.
- R2: A window lasts WIN_CYC reference cycles. A window is in range when its count of TDM rising edges lies within [`win_lo`, `win_hi`], both limits inclusive. A clock whose count lies above `win_hi` never qualifies.
- R3: `clk_good` rises only at the end of the GOOD_RUN-th consecutive in-range window (default 3). It is never high after fewer in-range windows.
- R4: `clk_good` falls at the end of the first window that is out of range.
- R5: A TDM clock that is too slow (below `win_lo`) or too fast (above `win_hi`) never raises `clk_good`, and the serial-clock enables stay off.
- R6: `bclk_en` and `lrclk_en` rise together exactly DLY_CYC+1 reference cycles after `clk_good` is first seen high, with the codec still in reset.
- R7: `codec_rst_n` rises only after both enables are on. It rises 3 reference cycles after a rising edge of `rx1x_clk`, which passes through a 2-flop synchronizer and then an edge register. `rx1x_clk` edges that arrive during the start delay do not release the codec.
- R8: `rst_hold_n` passes through a 2-flop synchronizer. While it is low, the sequencer is idle, with both enables off and the codec in reset. If the hold arrives in the same cycle as a receive-clock edge, the hold wins. When the hold is released, the full start delay runs again.
- R9: One cycle after `clk_good` falls, both enables turn off and `codec_rst_n` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock for measurement and sequencing |
| tdm_clk | input | 1 | TDM clock under test |
| rst_main_n | input | 1 | Asynchronous active-low reset of the whole block |
| rst_hold_n | input | 1 | Active-low hold that returns the sequencer to idle |
| rx1x_clk | input | 1 | Receive 1x clock; its rising edge releases the codec |
| win_lo | input | CNT_W | Lowest acceptable edge count per window |
| win_hi | input | CNT_W | Highest acceptable edge count per window |
| clk_good | output | 1 | TDM clock qualified |
| bclk_en | output | 1 | Bit-clock enable |
| lrclk_en | output | 1 | Frame (left/right) clock enable |
| codec_rst_n | output | 1 | Registered active-low codec reset |

## Verification
Two things can reach the sequencer in the same reference cycle: the synchronized edge of `rx1x_clk` and the synchronized hold request. Both pass through 2-flop synchronizers of equal depth. The bench therefore changes `rx1x_clk` and `rst_hold_n` at the same instant while the sequencer is waiting for the edge. It then expects the codec to stay in reset and the enables to fall three cycles later. A second collision is a bad window that ends while the block is running: the bench expects the enables and the codec release to drop exactly one cycle after `clk_good` falls.

// File: rtl/tdm_qual_pkg.sv
package tdm_qual_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_DELAY = 2'd1,
        SEQ_ARM   = 2'd2,
        SEQ_RUN   = 2'd3
    } seq_state_e;

endpackage

// File: rtl/tdm_edge_cnt.sv
// Free-running rising-edge counter in the TDM domain, Gray-coded output register.
module tdm_edge_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             tdm_clk,
    input  logic             arst_n,
    output logic [CNT_W-1:0] gray_o
);
    typedef struct packed {
        logic [CNT_W-1:0] bin;
        logic [CNT_W-1:0] gray;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d      = cnt_q;
        cnt_d.bin  = cnt_q.bin + 1'b1;
        cnt_d.gray = cnt_d.bin ^ (cnt_d.bin >> 1);
    end

    always_ff @(posedge tdm_clk or negedge arst_n) begin
        if (!arst_n) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign gray_o = cnt_q.gray;
endmodule

// File: rtl/tdm_gray_sync.sv
// Two-flop synchronizer for a Gray word, converted back to binary.
module tdm_gray_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] gray_i,
    output logic [W-1:0] bin_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = gray_i;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= sync_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_g2b
        assign bin_o[i] = ^(sync_q.s2 >> i);
    end
endmodule

// File: rtl/tdm_window_qual.sv
// Windowed edge-count comparison with a run-length filter against false positives.
module tdm_window_qual #(
    parameter int WIN_CYC  = 73,
    parameter int CNT_W    = 8,
    parameter int GOOD_RUN = 3
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic [CNT_W-1:0] cnt_bin_i,
    input  logic [CNT_W-1:0] lo_i,
    input  logic [CNT_W-1:0] hi_i,
    output logic             good_o
);
    localparam int WCW = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
    localparam int RW  = $clog2(GOOD_RUN + 1);
    localparam logic [WCW-1:0] WIN_LAST = WCW'(WIN_CYC - 1);
    localparam logic [RW-1:0]  RUN_FULL = RW'(GOOD_RUN);

    typedef struct packed {
        logic [WCW-1:0]   wcnt;
        logic [CNT_W-1:0] prev;
        logic [RW-1:0]    run;
        logic             good;
    } qual_t;

    qual_t qual_d, qual_q;
    logic [CNT_W-1:0] delta;
    logic             win_end;
    logic             in_rng;

    always_comb begin
        qual_d  = qual_q;
        win_end = (qual_q.wcnt == WIN_LAST);
        delta   = cnt_bin_i - qual_q.prev;
        in_rng  = (delta >= lo_i) && (delta <= hi_i);

        qual_d.wcnt = win_end ? '0 : qual_q.wcnt + 1'b1;

        if (win_end) begin
            qual_d.prev = cnt_bin_i;
            if (in_rng) begin
                if (qual_q.run != RUN_FULL) qual_d.run = qual_q.run + 1'b1;
                qual_d.good = (qual_d.run == RUN_FULL);
            end else begin
                qual_d.run  = '0;
                qual_d.good = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) qual_q <= '0;
        else         qual_q <= qual_d;
    end

    assign good_o = qual_q.good;
endmodule

// File: rtl/tdm_start_seq.sv
// Start-up sequencer: delay, serial-clock enables, codec release on receive-clock edge.
module tdm_start_seq
    import tdm_qual_pkg::*;
#(
    parameter int DLY_CYC = 101808
) (
    input  logic clk,
    input  logic arst_n,
    input  logic good_i,
    input  logic hold_n_i,
    input  logic rx1x_i,
    output logic bclk_en_o,
    output logic lrclk_en_o,
    output logic codec_rst_n_o
);
    localparam int DW = (DLY_CYC > 1) ? $clog2(DLY_CYC) : 1;
    localparam logic [DW-1:0] DLY_LAST = DW'(DLY_CYC - 1);

    typedef struct packed {
        seq_state_e  st;
        logic [DW-1:0] dcnt;
        logic        hs1;
        logic        hs2;
        logic        rs1;
        logic        rs2;
        logic        rs3;
        logic        bclk;
        logic        lrclk;
        logic        codec;
    } seq_t;

    seq_t seq_d, seq_q;
    logic rx_rise;
    logic run_ok;

    always_comb begin
        seq_d     = seq_q;
        seq_d.hs1 = hold_n_i;
        seq_d.hs2 = seq_q.hs1;
        seq_d.rs1 = rx1x_i;
        seq_d.rs2 = seq_q.rs1;
        seq_d.rs3 = seq_q.rs2;

        rx_rise = seq_q.rs2 & ~seq_q.rs3;
        run_ok  = good_i & seq_q.hs2;

        if (!run_ok) begin
            seq_d.st   = SEQ_IDLE;
            seq_d.dcnt = '0;
        end else begin
            unique case (seq_q.st)
                SEQ_IDLE: begin
                    seq_d.st   = SEQ_DELAY;
                    seq_d.dcnt = '0;
                end
                SEQ_DELAY: begin
                    if (seq_q.dcnt == DLY_LAST) seq_d.st   = SEQ_ARM;
                    else                        seq_d.dcnt = seq_q.dcnt + 1'b1;
                end
                SEQ_ARM: begin
                    if (rx_rise) seq_d.st = SEQ_RUN;
                end
                SEQ_RUN: seq_d.st = SEQ_RUN;
                default: seq_d.st = SEQ_IDLE;
            endcase
        end

        seq_d.bclk  = (seq_d.st == SEQ_ARM) || (seq_d.st == SEQ_RUN);
        seq_d.lrclk = (seq_d.st == SEQ_ARM) || (seq_d.st == SEQ_RUN);
        seq_d.codec = (seq_d.st == SEQ_RUN);
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) seq_q <= '{st: SEQ_IDLE, default: '0};
        else         seq_q <= seq_d;
    end

    assign bclk_en_o     = seq_q.bclk;
    assign lrclk_en_o    = seq_q.lrclk;
    assign codec_rst_n_o = seq_q.codec;
endmodule

// File: rtl/tdm_qual_seq.sv
module tdm_qual_seq #(
    parameter int WIN_CYC  = 73,
    parameter int CNT_W    = 8,
    parameter int GOOD_RUN = 3,
    parameter int DLY_CYC  = 101808
) (
    input  logic             ref_clk,
    input  logic             tdm_clk,
    input  logic             rst_main_n,
    input  logic             rst_hold_n,
    input  logic             rx1x_clk,
    input  logic [CNT_W-1:0] win_lo,
    input  logic [CNT_W-1:0] win_hi,
    output logic             clk_good,
    output logic             bclk_en,
    output logic             lrclk_en,
    output logic             codec_rst_n
);
    logic [CNT_W-1:0] tdm_gray;
    logic [CNT_W-1:0] tdm_bin;

    tdm_edge_cnt #(.CNT_W(CNT_W)) u_cnt (
        .tdm_clk (tdm_clk),
        .arst_n  (rst_main_n),
        .gray_o  (tdm_gray)
    );

    tdm_gray_sync #(.W(CNT_W)) u_sync (
        .clk    (ref_clk),
        .arst_n (rst_main_n),
        .gray_i (tdm_gray),
        .bin_o  (tdm_bin)
    );

    tdm_window_qual #(
        .WIN_CYC  (WIN_CYC),
        .CNT_W    (CNT_W),
        .GOOD_RUN (GOOD_RUN)
    ) u_qual (
        .clk       (ref_clk),
        .arst_n    (rst_main_n),
        .cnt_bin_i (tdm_bin),
        .lo_i      (win_lo),
        .hi_i      (win_hi),
        .good_o    (clk_good)
    );

    tdm_start_seq #(.DLY_CYC(DLY_CYC)) u_seq (
        .clk           (ref_clk),
        .arst_n        (rst_main_n),
        .good_i        (clk_good),
        .hold_n_i      (rst_hold_n),
        .rx1x_i        (rx1x_clk),
        .bclk_en_o     (bclk_en),
        .lrclk_en_o    (lrclk_en),
        .codec_rst_n_o (codec_rst_n)
    );
endmodule

// File: rtl/tdm_qual_seq_chk.sv
module tdm_qual_seq_chk (
    input logic ref_clk,
    input logic rst_main_n,
    input logic rst_hold_n,
    input logic clk_good,
    input logic bclk_en,
    input logic lrclk_en,
    input logic codec_rst_n
);
    // R9
    en_after_good_chk: assert property (@(posedge ref_clk) disable iff (!rst_main_n)
        bclk_en |-> $past(clk_good));

    // R7
    codec_needs_en_chk: assert property (@(posedge ref_clk) disable iff (!rst_main_n)
        codec_rst_n |-> (bclk_en && lrclk_en));

    // R7
    codec_rise_late_chk: assert property (@(posedge ref_clk) disable iff (!rst_main_n)
        $rose(codec_rst_n) |-> $past(bclk_en));

    // R9
    loss_drop_chk: assert property (@(posedge ref_clk) disable iff (!rst_main_n)
        $fell(clk_good) |=> (!bclk_en && !lrclk_en && !codec_rst_n));

    // R8
    hold_idle_chk: assert property (@(posedge ref_clk) disable iff (!rst_main_n)
        !$past(rst_hold_n, 2) |=> (!codec_rst_n && !bclk_en));

    // R6
    en_pair_chk: assert property (@(posedge ref_clk) disable iff (!rst_main_n)
        $rose(bclk_en) |-> ($rose(lrclk_en) && !codec_rst_n));
endmodule

bind tdm_qual_seq tdm_qual_seq_chk u_chk (
    .ref_clk     (ref_clk),
    .rst_main_n  (rst_main_n),
    .rst_hold_n  (rst_hold_n),
    .clk_good    (clk_good),
    .bclk_en     (bclk_en),
    .lrclk_en    (lrclk_en),
    .codec_rst_n (codec_rst_n)
);

// File: tb/tdm_qual_seq_tb.sv
`timescale 1ns/1ps
module tdm_qual_seq_tb;
    localparam int WIN  = 50;
    localparam int CW   = 8;
    localparam int RUNS = 3;
    localparam int DLY  = 40;

    logic          ref_clk = 1'b0;
    logic          tdm_clk = 1'b0;
    logic          rst_main_n = 1'b0;
    logic          rst_hold_n = 1'b1;
    logic          rx1x_clk = 1'b0;
    logic [CW-1:0] win_lo = 8'd22;
    logic [CW-1:0] win_hi = 8'd28;
    logic          clk_good, bclk_en, lrclk_en, codec_rst_n;

    int tdm_half = 10;
    int cyc = 0;
    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        int         at;
        logic [3:0] v;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    tdm_qual_seq #(.WIN_CYC(WIN), .CNT_W(CW), .GOOD_RUN(RUNS), .DLY_CYC(DLY)) u_dut (
        .ref_clk(ref_clk), .tdm_clk(tdm_clk), .rst_main_n(rst_main_n),
        .rst_hold_n(rst_hold_n), .rx1x_clk(rx1x_clk), .win_lo(win_lo), .win_hi(win_hi),
        .clk_good(clk_good), .bclk_en(bclk_en), .lrclk_en(lrclk_en), .codec_rst_n(codec_rst_n)
    );

    always #5 ref_clk = ~ref_clk;
    always begin
        #(tdm_half) tdm_clk = ~tdm_clk;
    end

    function automatic logic [3:0] snap();
        return {clk_good, bclk_en, lrclk_en, codec_rst_n};
    endfunction

    // Monitor: pops expected snapshots as their cycle arrives.
    always @(negedge ref_clk) begin
        cyc = cyc + 1;
        while (exp_q.size() > 0 && exp_q[0].at <= cyc) begin
            exp_t e;
            e = exp_q.pop_front();
            n_tests++;
            if (e.at != cyc || snap() !== e.v) begin
                n_fail++;
                $display("[TB] FAIL %s cyc %0d: actual %b expected %b", e.tag, cyc, snap(), e.v);
            end
        end
    end

    task automatic tick();
        @(negedge ref_clk);
        #1;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) tick();
    endtask

    task automatic expect_at(input int c, input logic [3:0] v, input string tag);
        exp_t e;
        e.at = c; e.v = v; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("[TB] FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic poll_good(input logic val, input int limit, output int c);
        c = -1;
        for (int k = 0; k < limit && c < 0; k++) begin
            tick();
            if (clk_good === val) c = cyc;
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge ref_clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("[TB] FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int rel, c0, cr, cx, cy, cz, cw, cl;
        int seen;

        // R1: outputs held low in reset
        repeat (5) tick();
        check(snap() == 4'b0000, "R1 reset state", snap(), 0);

        // R3: three in-range windows needed
        rst_main_n = 1'b1;
        rel = cyc;
        wait_until(rel + 3*WIN - 3);
        check(clk_good == 1'b0, "R3 no good after two windows", clk_good, 0);
        poll_good(1'b1, 12, c0);
        check(c0 > 0 && c0 <= rel + 3*WIN + 3, "R3 good after third window", c0, rel + 3*WIN);

        // R6 / R7: delay, enables, codec release on rx edge only after delay
        expect_at(c0 + DLY,      4'b1000, "R6 enables off during delay");
        expect_at(c0 + DLY + 1,  4'b1110, "R6 enables on after delay, R7 codec held");
        expect_at(c0 + DLY + 10, 4'b1110, "R7 codec held without rx edge");
        wait_until(c0 + 5);  rx1x_clk = 1'b1;
        wait_until(c0 + 15); rx1x_clk = 1'b0;
        wait_until(c0 + DLY + 12);
        rx1x_clk = 1'b1; cr = cyc;
        expect_at(cr + 2, 4'b1110, "R7 codec not yet released");
        expect_at(cr + 3, 4'b1111, "R7 codec released on rx edge");
        wait_until(cr + 6); rx1x_clk = 1'b0;

        // R8: hold alone
        wait_until(cr + 10); rst_hold_n = 1'b0; cx = cyc;
        expect_at(cx + 2, 4'b1111, "R8 hold not yet through sync");
        expect_at(cx + 3, 4'b1000, "R8 hold forces idle");
        wait_until(cx + 6); rst_hold_n = 1'b1; cy = cyc;
        expect_at(cy + 2 + DLY, 4'b1000, "R8 full delay reruns");
        expect_at(cy + 3 + DLY, 4'b1110, "R8 enables after rerun delay");

        // R8: hold and rx edge land in the same cycle, hold wins
        wait_until(cy + DLY + 8);
        rx1x_clk = 1'b1; rst_hold_n = 1'b0; cz = cyc;
        expect_at(cz + 2, 4'b1110, "R8 collision before sync");
        expect_at(cz + 3, 4'b1000, "R8 collision hold wins");
        wait_until(cz + 6); rx1x_clk = 1'b0; rst_hold_n = 1'b1;
        wait_until(cz + DLY + 15);
        rx1x_clk = 1'b1; cw = cyc;
        expect_at(cw + 3, 4'b1111, "R7 release after collision recovery");
        wait_until(cw + 6); rx1x_clk = 1'b0;

        // R1: asynchronous reset while running
        tick(); #2;
        rst_main_n = 1'b0;
        #1;
        check(snap() == 4'b0000, "R1 async reset clears outputs", snap(), 0);

        // R5: too-slow clock
        tdm_half = 20;
        tick(); rst_main_n = 1'b1;
        seen = 0;
        for (int k = 0; k < 8*WIN; k++) begin
            tick();
            if (clk_good || bclk_en || lrclk_en) seen = 1;
        end
        check(seen == 0, "R5 slow clock rejected", seen, 0);

        // R2: nominal clock but window upper limit below its count
        win_hi = 8'd20; tdm_half = 10;
        seen = 0;
        for (int k = 0; k < 8*WIN; k++) begin
            tick();
            if (clk_good) seen = 1;
        end
        check(seen == 0, "R2 count above win_hi rejected", seen, 0);

        // R2: restore range, clock qualifies
        win_hi = 8'd28;
        poll_good(1'b1, 5*WIN, c0);
        check(c0 > 0, "R2 count inside range accepted", c0, 1);
        expect_at(c0 + DLY + 1, 4'b1110, "R6 enables after delay second run");
        wait_until(c0 + DLY + 3);
        rx1x_clk = 1'b1; cr = cyc;
        expect_at(cr + 3, 4'b1111, "R7 release second run");
        wait_until(cr + 5); rx1x_clk = 1'b0;

        // R4 / R5 / R9: switch to too-fast clock while running
        tdm_half = 6;
        poll_good(1'b0, 2*WIN + 5, cl);
        check(cl > 0, "R4 good falls on fast clock", cl, 1);
        check(bclk_en && codec_rst_n, "R9 outputs still on in fall cycle",
              {bclk_en, codec_rst_n}, 3);
        expect_at(cl + 1, 4'b0000, "R9 enables and codec drop after loss");
        seen = 0;
        for (int k = 0; k < 6*WIN; k++) begin
            tick();
            if (clk_good) seen = 1;
        end
        check(seen == 0, "R5 fast clock rejected", seen, 0);
        check(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);

        finish_run();
    end
endmodule